// File: doc/BRIEF.md
# DC-Offset Removal Filter with Freeze

This block sits after a decimation filter and strips the slowly varying DC component from a stream of signed audio samples. Samples arrive with a valid strobe and a channel index. For each channel the block keeps its own running estimate of the offset. It subtracts that estimate from every sample and returns the corrected sample, tagged with the same channel, one clock later.

Two controls select the behaviour. The enable control lets the estimate track the input. The freeze control pins every channel's estimate at its present value, while the block keeps subtracting that value. This supports a system offset calibration. The filter first runs enabled until the estimate settles. Then, in the same cycle, enable is dropped and freeze is raised, so the learned offset stays applied from then on.

The estimate is a leaky integrator with a shift of `SHIFT_K`. The corrected result is clamped to the sample range instead of wrapping around.

Top module: `dc_trim_top`

## Requirements
- R1: Every sample accepted on a clock edge with `in_vld` high appears on the next edge with `out_vld` high and `out_ch` equal to its `in_ch`. `out_vld` is low after any edge where `in_vld` was low.
- R2: With `hp_en` = 1 and `hold_en` = 0, the output is the input minus the channel's offset. The offset is the accumulator shifted arithmetically right by `SHIFT_K` (floor). The offset used is the one held before this sample. The accumulator then becomes acc + (((x << SHIFT_K) - acc) >>> SHIFT_K).
- R3: With `hp_en` = 0 and `hold_en` = 0, the output equals the input, and no channel's accumulator changes.
- R4: With `hold_en` = 1, the stored offset of the sample's channel is still subtracted, whatever `hp_en` is, and no accumulator changes.
- R5: Each channel has its own accumulator. A sample only touches the accumulator selected by its `in_ch`.
- R6: The subtraction result saturates. Results above 8388607 give 8388607, and results below -8388608 give -8388608 (24-bit two's complement).
- R7: Reset (asynchronous, active low, released after two clock edges) clears every accumulator to zero and holds `out_vld` low.
- R8: If `hp_en` falls and `hold_en` rises on the same edge after the filter has settled, later outputs keep subtracting the offset learned up to that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input sample strobe |
| in_ch | input | CH_W | Channel of the input sample |
| in_smp | input | SAMPLE_W | Input sample, two's complement |
| hp_en | input | 1 | Let the offset estimate track the input |
| hold_en | input | 1 | Freeze estimates, keep subtracting them |
| out_vld | output | 1 | Output sample strobe |
| out_ch | output | CH_W | Channel of the output sample |
| out_smp | output | SAMPLE_W | Offset-corrected, saturated sample |

## Verification
Saturation is the hardest case to reach from the ports. It only occurs once a channel's estimate has been driven close to one rail, and then a sample from the opposite rail arrives. The bench therefore feeds each channel several thousand samples at a full-scale level, with the two channels at opposite polarities, and then sends the opposite full-scale code. The freeze path needs a settled estimate in the same way, so the calibration phase reuses a long tracking run before it switches both controls on a single edge.

// File: rtl/dc_trim_pkg.sv
package dc_trim_pkg;
  typedef enum logic [1:0] {
    TRIM_PASS  = 2'd0,
    TRIM_TRACK = 2'd1,
    TRIM_HOLD  = 2'd2
  } trim_mode_e;

  function automatic trim_mode_e decode_mode(input logic hp, input logic hold);
    if (hold)    return TRIM_HOLD;
    else if (hp) return TRIM_TRACK;
    else         return TRIM_PASS;
  endfunction
endpackage

// File: rtl/dc_trim_rst_sync.sv
module dc_trim_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/dc_trim_est_bank.sv
module dc_trim_est_bank #(
  parameter int NUM_CH   = 2,
  parameter int SAMPLE_W = 24,
  parameter int SHIFT_K  = 12,
  parameter int CH_W     = 1,
  localparam int ACC_W   = SAMPLE_W + SHIFT_K
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      upd_vld,
  input  logic [CH_W-1:0]           upd_ch,
  input  logic [SAMPLE_W-1:0]       upd_smp,
  input  logic [CH_W-1:0]           rd_ch,
  output logic [SAMPLE_W-1:0]       rd_off,
  output logic [NUM_CH*ACC_W-1:0]   acc_flat
);
  logic [SAMPLE_W-1:0] off_arr [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] acc_d;
    logic signed [ACC_W:0]   tgt;
    logic signed [ACC_W:0]   diff;
    logic signed [ACC_W:0]   step;
    logic                    hit;

    always_comb begin
      hit   = upd_vld && (upd_ch == CH_W'(g));
      tgt   = {upd_smp[SAMPLE_W-1], upd_smp, {SHIFT_K{1'b0}}};
      diff  = tgt - {acc_q[ACC_W-1], acc_q};
      step  = diff >>> SHIFT_K;
      acc_d = hit ? (acc_q + step[ACC_W-1:0]) : acc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else if (hit) acc_q <= acc_d;
    end

    assign off_arr[g] = acc_q[ACC_W-1:SHIFT_K];
    assign acc_flat[g*ACC_W +: ACC_W] = acc_q;
  end

  always_comb begin
    rd_off = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_ch == CH_W'(i)) rd_off = off_arr[i];
    end
  end
endmodule

// File: rtl/dc_trim_sub_sat.sv
module dc_trim_sub_sat #(
  parameter int SAMPLE_W = 24,
  parameter int CH_W     = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic [CH_W-1:0]     in_ch,
  input  logic [SAMPLE_W-1:0] in_smp,
  input  logic [SAMPLE_W-1:0] off,
  input  logic                use_off,
  output logic                out_vld,
  output logic [CH_W-1:0]     out_ch,
  output logic [SAMPLE_W-1:0] out_smp
);
  localparam logic [SAMPLE_W-1:0] POS_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [SAMPLE_W-1:0] NEG_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic signed [SAMPLE_W:0] wide;
  logic [SAMPLE_W-1:0]      sub_eff;
  logic [SAMPLE_W-1:0]      res_d;

  always_comb begin
    sub_eff = use_off ? off : '0;
    wide    = {in_smp[SAMPLE_W-1], in_smp} - {sub_eff[SAMPLE_W-1], sub_eff};
    if (wide[SAMPLE_W] != wide[SAMPLE_W-1])
      res_d = wide[SAMPLE_W] ? NEG_MIN : POS_MAX;
    else
      res_d = wide[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= in_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_ch  <= '0;
      out_smp <= '0;
    end else if (in_vld) begin
      out_ch  <= in_ch;
      out_smp <= res_d;
    end
  end
endmodule

// File: rtl/dc_trim_top.sv
module dc_trim_top #(
  parameter int NUM_CH   = 2,
  parameter int SAMPLE_W = 24,
  parameter int SHIFT_K  = 12,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ACC_W   = SAMPLE_W + SHIFT_K
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic [CH_W-1:0]     in_ch,
  input  logic [SAMPLE_W-1:0] in_smp,
  input  logic                hp_en,
  input  logic                hold_en,
  output logic                out_vld,
  output logic [CH_W-1:0]     out_ch,
  output logic [SAMPLE_W-1:0] out_smp
);
  import dc_trim_pkg::*;

  logic                    srst_n;
  trim_mode_e              mode;
  logic                    upd_vld;
  logic                    use_off;
  logic [SAMPLE_W-1:0]     cur_off;
  logic [NUM_CH*ACC_W-1:0] acc_flat;

  always_comb begin
    mode    = decode_mode(hp_en, hold_en);
    upd_vld = in_vld && (mode == TRIM_TRACK);
    use_off = (mode != TRIM_PASS);
  end

  dc_trim_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  dc_trim_est_bank #(
    .NUM_CH   (NUM_CH),
    .SAMPLE_W (SAMPLE_W),
    .SHIFT_K  (SHIFT_K),
    .CH_W     (CH_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (srst_n),
    .upd_vld  (upd_vld),
    .upd_ch   (in_ch),
    .upd_smp  (in_smp),
    .rd_ch    (in_ch),
    .rd_off   (cur_off),
    .acc_flat (acc_flat)
  );

  dc_trim_sub_sat #(
    .SAMPLE_W (SAMPLE_W),
    .CH_W     (CH_W)
  ) u_sub (
    .clk     (clk),
    .rst_n   (srst_n),
    .in_vld  (in_vld),
    .in_ch   (in_ch),
    .in_smp  (in_smp),
    .off     (cur_off),
    .use_off (use_off),
    .out_vld (out_vld),
    .out_ch  (out_ch),
    .out_smp (out_smp)
  );
endmodule

// File: rtl/dc_trim_chk.sv
module dc_trim_chk #(
  parameter int SAMPLE_W   = 24,
  parameter int CH_W       = 1,
  parameter int ACC_FLAT_W = 72
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_vld,
  input logic [CH_W-1:0]       in_ch,
  input logic [SAMPLE_W-1:0]   in_smp,
  input logic                  hp_en,
  input logic                  hold_en,
  input logic                  out_vld,
  input logic [CH_W-1:0]       out_ch,
  input logic [SAMPLE_W-1:0]   out_smp,
  input logic [ACC_FLAT_W-1:0] acc_flat
);
  // R1
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  // R1
  vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  // R1
  ch_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (out_ch == $past(in_ch)));

  // R3
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !hp_en && !hold_en) |=> (out_smp == $past(in_smp)));

  // R3
  idle_est_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_en |=> $stable(acc_flat));

  // R4
  hold_est_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_en |=> $stable(acc_flat));
endmodule

bind dc_trim_top dc_trim_chk #(
  .SAMPLE_W   (SAMPLE_W),
  .CH_W       (CH_W),
  .ACC_FLAT_W (NUM_CH*ACC_W)
) u_chk (
  .clk      (clk),
  .rst_n    (srst_n),
  .in_vld   (in_vld),
  .in_ch    (in_ch),
  .in_smp   (in_smp),
  .hp_en    (hp_en),
  .hold_en  (hold_en),
  .out_vld  (out_vld),
  .out_ch   (out_ch),
  .out_smp  (out_smp),
  .acc_flat (acc_flat)
);

// File: tb/dc_trim_top_test.sv
module dc_trim_top_test;
  localparam int NUM_CH = 2;
  localparam int SW     = 24;
  localparam int K      = 8;
  localparam int CW     = 1;
  localparam longint PMAX = 64'sd8388607;
  localparam longint NMIN = -64'sd8388608;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_vld = 1'b0;
  logic [CW-1:0] in_ch = '0;
  logic [SW-1:0] in_smp = '0;
  logic          hp_en = 1'b0;
  logic          hold_en = 1'b0;
  logic          out_vld;
  logic [CW-1:0] out_ch;
  logic [SW-1:0] out_smp;

  int     checks = 0;
  int     fails  = 0;
  bit     cmp_on = 1'b0;
  string  tag = "R7";
  longint acc [NUM_CH];
  bit     exp_vld = 1'b0;
  int     exp_ch = 0;
  longint exp_smp = 0;

  always #5 clk = ~clk;

  dc_trim_top #(.NUM_CH(NUM_CH), .SAMPLE_W(SW), .SHIFT_K(K)) uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ch(in_ch), .in_smp(in_smp),
    .hp_en(hp_en), .hold_en(hold_en),
    .out_vld(out_vld), .out_ch(out_ch), .out_smp(out_smp)
  );

  // Behavioural reference: one result per accepted sample, one clock later.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) acc[i] = 0;
      exp_vld = 1'b0;
    end else begin
      exp_vld = in_vld;
      if (in_vld) begin
        longint x, off, y;
        int c;
        c   = int'(in_ch);
        x   = longint'($signed(in_smp));
        off = acc[c] >>> K;
        y   = (hp_en || hold_en) ? (x - off) : x;
        if (hp_en && !hold_en) acc[c] = acc[c] + (((x <<< K) - acc[c]) >>> K);
        if (y > PMAX) y = PMAX;
        if (y < NMIN) y = NMIN;
        exp_ch  = c;
        exp_smp = y;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (out_vld !== exp_vld) begin
        fails++;
        $display("FAIL %s out_vld actual %0b expected %0b", tag, out_vld, exp_vld);
      end else if (exp_vld) begin
        if (int'(out_ch) != exp_ch || longint'($signed(out_smp)) != exp_smp) begin
          fails++;
          $display("FAIL %s ch/sample actual %0d/%0d expected %0d/%0d", tag,
                   out_ch, $signed(out_smp), exp_ch, exp_smp);
        end
      end
    end
  end

  task automatic report_end();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic send(input int ch, input longint x, input bit hp, input bit hold);
    @(negedge clk);
    in_vld  = 1'b1;
    in_ch   = CW'(ch);
    in_smp  = SW'(x);
    hp_en   = hp;
    hold_en = hold;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
    end
  endtask

  task automatic do_reset();
    cmp_on = 1'b0;
    @(negedge clk);
    in_vld = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    // R7: output strobe low while reset is held
    checks++;
    if (out_vld !== 1'b0) begin
      fails++;
      $display("FAIL R7 out_vld in reset actual %0b expected 0", out_vld);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;
  endtask

  function automatic longint noise();
    return longint'($urandom_range(0, 200)) - 100;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual running expected done");
    report_end();
  end

  initial begin
    tag = "R7";
    do_reset();

    // R3: disabled filter passes arbitrary samples through
    tag = "R3";
    for (int i = 0; i < 60; i++) begin
      longint v;
      v = longint'($signed(SW'($urandom)));
      send(i % NUM_CH, v, 1'b0, 1'b0);
      if (i % 7 == 3) idle(1);
    end

    // R2 / R5: track opposite offsets on the two channels, with gaps (R1)
    tag = "R2";
    for (int i = 0; i < 4000; i++) begin
      send(0, 3000 + noise(), 1'b1, 1'b0);
      send(1, -5000 + noise(), 1'b1, 1'b0);
      if (i % 50 == 0) idle(2);
    end

    // R8: drop enable and raise freeze on one edge
    tag = "R8";
    for (int i = 0; i < 40; i++) begin
      send(i % NUM_CH, longint'(i) * 1000 - 20000, 1'b0, 1'b1);
    end

    // R4: freeze dominates even with enable high
    tag = "R4";
    for (int i = 0; i < 40; i++) begin
      send(i % NUM_CH, 50000 - longint'(i) * 777, 1'b1, 1'b1);
    end

    // R3: pass-through after freeze, then R5 estimates resume unchanged
    tag = "R3";
    for (int i = 0; i < 20; i++) send(i % NUM_CH, longint'(i) * 31, 1'b0, 1'b0);
    tag = "R5";
    for (int i = 0; i < 30; i++) send(0, 2000, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) send(1, -5000, 1'b1, 1'b0);

    // R6: push estimates to opposite rails, then hit the other rail
    tag = "R6";
    for (int i = 0; i < 4000; i++) begin
      send(0, NMIN, 1'b1, 1'b0);
      send(1, PMAX, 1'b1, 1'b0);
    end
    send(0, PMAX, 1'b1, 1'b0);
    send(1, NMIN, 1'b1, 1'b0);
    send(0, PMAX, 1'b0, 1'b1);
    send(1, NMIN, 1'b0, 1'b1);
    idle(2);

    // R7: reset mid-run clears estimates; first outputs equal inputs
    tag = "R7";
    do_reset();
    send(0, 12345, 1'b1, 1'b0);
    send(1, -4321, 1'b1, 1'b0);
    send(0, 777, 1'b0, 1'b1);
    idle(3);

    cmp_on = 1'b0;
    report_end();
  end
endmodule